// File: doc/BRIEF.md
# Serial Configuration Memory Slave (two-wire bus)

This block is a two-wire serial-bus slave that emulates a 256-byte configuration memory. A module controller reads identification and timing bytes from it over the clock and data lines, and may also write bytes back. The block oversamples both bus lines with a fast system clock, drops short pulses, detects bus start and stop conditions, and answers only to its own device address. The low three bits of that address come from strap inputs, so eight copies can share one bus. All data sits in a register array inside the block. A side port lets the surrounding logic load initial content without any bus traffic.

The supported transfers are single-byte and multi-byte writes, reads at the current pointer, random reads (a pointer write followed by a repeated start), and sequential reads. When a STOP ends a write that stored data, the block enters a busy window of a parameterised number of cycles, which stands in for the nonvolatile programming time. During that window it does not acknowledge its own address. A checksum flag reports whether byte 63 equals the low eight bits of the sum of bytes 0 to 62.

Top module: `ee_spd_slave`

## Requirements
- R1: The device address byte is 1010b in bits 7:4, the strap value in bits 3:1 and read(1)/write(0) in bit 0. The block acknowledges it only when bits 7:1 match, by pulling SDA low during the ninth clock. On a mismatch SDA stays released for the rest of the transfer.
- R2: In a write, the first byte after the address is the word pointer. Each later byte is stored at the pointer, which then advances. Every one of these bytes is acknowledged.
- R3: The pointer advances after each byte written or read and wraps from 255 to 0.
- R4: A read returns the bytes starting at the pointer, MSB first. A repeated start after a pointer write gives a random read. A read with no pointer write continues from where the pointer stands. The read goes on while the master acknowledges. A master NACK ends it, and SDA then stays released.
- R5: A STOP that ends a write which stored at least one byte starts a busy window of BUSY_CYC cycles. During the window the device address is not acknowledged. Afterwards it is acknowledged again.
- R6: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks has no effect: it creates no extra bit, no START and no STOP.
- R7: When ld_en is high, ld_data is written to byte ld_addr on that clock.
- R8: csum_ok is high exactly when byte 63 equals the sum of bytes 0 to 62 modulo 256.
- R9: After reset, sda_oe is low, the pointer is 0, no busy window is active and every byte is 0.
- R10: The block changes sda_oe only while SCL is low, apart from releasing it on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Low device address bits |
| ld_en | input | 1 | Direct load strobe |
| ld_addr | input | 8 | Byte index for the direct load |
| ld_data | input | 8 | Byte value for the direct load |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| csum_ok | output | 1 | Byte 63 matches the checksum of bytes 0 to 62 |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it signals START or STOP. They also assume that every real SCL and SDA level lasts well over FILT_CYC clocks, and that the direct load port stays idle while a bus write is storing data. The bench master holds each half bit period for 40 system clocks and moves SDA only in the middle of the low phase. Its glitches are deliberately shorter than FILT_CYC, and all loads finish before any bus traffic begins.

// File: rtl/ee_spd_pkg.sv
package ee_spd_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_WADDR,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_TYPE, strap};
    endfunction

endpackage

// File: rtl/ee_glitch_filt.sv
module ee_glitch_filt #(
    parameter int FILT_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            clean <= 1'b1;
            cnt   <= '0;
        end else begin
            sync <= {sync[0], raw};
            if (sync[1] == clean) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_CYC - 1)) begin
                clean <= sync[1];
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: the clean level moves only after a full run of differing samples
    assert_filter_run_R6: assert property (@(posedge clk) disable iff (rst)
        $changed(clean) |-> $past(cnt) == CW'(FILT_CYC - 1));

endmodule

// File: rtl/ee_bus_cond.sv
module ee_bus_cond
    import ee_spd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop  = scl_f & scl_q & ~sda_q & sda_f;
        ev.rise  = scl_f & ~scl_q;
        ev.fall  = ~scl_f & scl_q;
        ev.sda   = sda_f;
    end

endmodule

// File: rtl/ee_engine.sv
module ee_engine
    import ee_spd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BUSY_CYC = 2_000_000,
    parameter int LOW_N    = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_ev_t                ev,
    input  logic [2:0]             strap,
    input  logic                   ld_en,
    input  logic [ADDR_W-1:0]      ld_addr,
    input  logic [7:0]             ld_data,
    output logic                   oe,
    output logic [LOW_N-1:0][7:0]  low_bytes
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BW    = $clog2(BUSY_CYC + 1);

    logic [7:0]        mem [DEPTH];
    phase_e            ph;
    logic [3:0]        bitcnt;
    logic              ackph;
    logic [7:0]        sh, tx;
    logic [ADDR_W-1:0] ptr;
    logic              wrote;
    logic [BW-1:0]     busy_cnt;
    logic              byte_ok, rx_done, wr_en;

    assign rx_done = ev.fall && bitcnt == 4'd8 && !ackph;
    assign byte_ok = (ph != PH_DEV) || (dev_match(sh, strap) && busy_cnt == '0);
    assign wr_en   = (ph == PH_WDATA) && rx_done && !ev.start && !ev.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            bitcnt   <= '0;
            ackph    <= 1'b0;
            oe       <= 1'b0;
            sh       <= '0;
            tx       <= '0;
            ptr      <= '0;
            wrote    <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (ev.stop) begin
                ph     <= PH_IDLE;
                oe     <= 1'b0;
                ackph  <= 1'b0;
                bitcnt <= '0;
                wrote  <= 1'b0;
                if (wrote) busy_cnt <= BW'(BUSY_CYC);
            end else if (ev.start) begin
                ph     <= PH_DEV;
                oe     <= 1'b0;
                ackph  <= 1'b0;
                bitcnt <= '0;
            end else begin
                case (ph)
                    PH_DEV, PH_WADDR, PH_WDATA: begin
                        if (ev.rise && bitcnt < 4'd8 && !ackph) begin
                            sh     <= {sh[6:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (rx_done) begin
                            ackph <= 1'b1;
                            oe    <= byte_ok;
                            if (!byte_ok) ph <= PH_SKIP;
                            if (ph == PH_WADDR) ptr <= sh[ADDR_W-1:0];
                            if (ph == PH_WDATA) begin
                                ptr   <= ptr + 1'b1;
                                wrote <= 1'b1;
                            end
                        end else if (ev.fall && ackph) begin
                            ackph  <= 1'b0;
                            bitcnt <= '0;
                            oe     <= 1'b0;
                            if (ph == PH_DEV) begin
                                if (sh[0]) begin
                                    ph <= PH_RDATA;
                                    tx <= mem[ptr];
                                    oe <= ~mem[ptr][7];
                                end else begin
                                    ph <= PH_WADDR;
                                end
                            end else begin
                                ph <= PH_WDATA;
                            end
                        end
                    end
                    PH_RDATA: begin
                        if (ev.fall && bitcnt < 4'd7) begin
                            tx     <= {tx[6:0], 1'b0};
                            oe     <= ~tx[6];
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == 4'd7) begin
                            oe     <= 1'b0;
                            bitcnt <= 4'd8;
                            ptr    <= ptr + 1'b1;
                        end else if (ev.rise && bitcnt == 4'd8) begin
                            if (ev.sda) ph <= PH_SKIP;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            tx     <= mem[ptr];
                            oe     <= ~mem[ptr][7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (wr_en) begin
            mem[ptr] <= sh;
        end
    end

    for (genvar g = 0; g < LOW_N; g++) begin : g_low
        assign low_bytes[g] = mem[g];
    end

    // R5: no drive at all while the programming window runs
    assert_busy_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        busy_cnt != '0 |-> !oe);

    // R1: a foreign address byte is never acknowledged
    assert_foreign_noack_R1: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DEV && rx_done && !dev_match(sh, strap)) |=> !oe);

    // R3: apart from a pointer load the pointer only steps by one, wrapping
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        ($changed(ptr) && $past(ph) != PH_WADDR) |-> ptr == $past(ptr) + 1'b1);

    // R4: once the transfer is abandoned SDA stays released
    assert_skip_release_R4: assert property (@(posedge clk) disable iff (rst)
        ph == PH_SKIP |-> !oe);

    // R10: drive changes follow an SCL fall, START or STOP
    assert_drive_timing_R10: assert property (@(posedge clk) disable iff (rst)
        $changed(oe) |-> $past(ev.fall || ev.start || ev.stop));

endmodule

// File: rtl/ee_sum_check.sv
module ee_sum_check #(
    parameter int N = 64
) (
    input  logic [N-1:0][7:0] bytes_in,
    output logic              ok
);
    logic [7:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N - 1; i++) acc = acc + bytes_in[i];
        ok = (acc == bytes_in[N-1]);
    end

endmodule

// File: rtl/ee_spd_slave.sv
module ee_spd_slave
    import ee_spd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int FILT_CYC = 10,
    parameter int BUSY_CYC = 2_000_000,
    parameter int SUM_N    = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    output logic              sda_oe,
    output logic              csum_ok
);
    logic [1:0]           raw_v, clean_v;
    bus_ev_t              ev;
    logic [SUM_N-1:0][7:0] low_bytes;

    assign raw_v = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        ee_glitch_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_v[g]),
            .clean (clean_v[g])
        );
    end

    ee_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_f (clean_v[0]),
        .sda_f (clean_v[1]),
        .ev    (ev)
    );

    ee_engine #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .LOW_N(SUM_N)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (strap),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .oe        (sda_oe),
        .low_bytes (low_bytes)
    );

    ee_sum_check #(.N(SUM_N)) u_sum (
        .bytes_in (low_bytes),
        .ok       (csum_ok)
    );

endmodule

// File: tb/ee_spd_slave_test.sv
module ee_spd_slave_test;
    localparam int FILT = 10;
    localparam int BUSY = 3000;
    localparam int HP   = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = '0, ld_data = '0;
    logic       sda_oe, csum_ok;
    wire        sda_bus = !(m_low || sda_oe);

    int checks = 0, bad = 0, r10_viol = 0;
    bit finished = 0;
    logic [7:0] model [256];
    logic oe_prev = 1'b0, scl_prev = 1'b1;

    always #2.5 clk = ~clk;

    ee_spd_slave #(.FILT_CYC(FILT), .BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .strap(strap),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .sda_oe(sda_oe), .csum_ok(csum_ok));

    // per-clock reference rule for R10: no change of drive while SCL stays high
    always @(negedge clk) begin
        if (!rst && scl && scl_prev && sda_oe && !oe_prev) r10_viol++;
        oe_prev  <= sda_oe;
        scl_prev <= scl;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_low = 1'b0; step(HP/2); scl = 1'b1; step(HP);
        m_low = 1'b1; step(HP); scl = 1'b0; step(1);
    endtask

    task automatic bus_stop();
        step(HP/2); m_low = 1'b1; step(HP/2); scl = 1'b1; step(HP);
        m_low = 1'b0; step(HP);
    endtask

    task automatic bit_x(input logic b, input bit glitch, output logic s);
        step(HP/2); m_low = !b;
        if (glitch) begin
            step(4); scl = 1'b1; step(FILT-4); scl = 1'b0; step(HP/2 - FILT);
            scl = 1'b1; step(HP/4); s = sda_bus;
            if (b) begin m_low = 1'b1; step(FILT-4); m_low = 1'b0; end
            else step(FILT-4);
            step(HP/4 - FILT + 4);
        end else begin
            step(HP/2); scl = 1'b1; step(HP/2); s = sda_bus; step(HP/2);
        end
        scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d, input bit glitch, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(d[i], glitch, s);
        bit_x(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic rd_byte(input bit mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin bit_x(1'b1, 1'b0, s); d[i] = s; end
        bit_x(!mack, 1'b0, s);
    endtask

    task automatic load(input int a, input int v);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_addr = 8'(a); ld_data = 8'(v);
        step(1); ld_en = 1'b0;
        model[a] = 8'(v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        int sum;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        step(5); rst = 1'b0; step(2);

        check("R9 reset drive", sda_oe, 0);
        check("R8 R9 zero array sums", csum_ok, 1);

        sum = 0;
        for (int i = 0; i < 63; i++) begin load(i, i*7 + 3); sum += i*7 + 3; end
        load(63, sum & 255); step(2);
        check("R7 R8 checksum matches", csum_ok, 1);
        load(63, (sum + 1) & 255); step(2);
        check("R8 checksum mismatch", csum_ok, 0);
        load(63, sum & 255); step(2);

        // R1 foreign address
        bus_start(); wr_byte(8'b1010_011_0, 0, ack);
        check("R1 foreign address nack", ack, 0);
        step(HP); check("R1 stays released", sda_oe, 0);
        bus_stop();

        // R4 random read from 5
        bus_start(); wr_byte(8'b1010_101_0, 0, ack);
        check("R1 own address ack", ack, 1);
        wr_byte(8'h05, 0, ack); check("R2 pointer ack", ack, 1);
        bus_start(); wr_byte(8'b1010_101_1, 0, ack);
        check("R4 read address ack", ack, 1);
        rd_byte(1, d); check("R4 random read byte 5", d, model[5]);
        rd_byte(1, d); check("R4 sequential byte 6", d, model[6]);
        rd_byte(0, d); check("R4 sequential byte 7", d, model[7]);
        step(HP); check("R4 released after nack", sda_oe, 0);
        bus_stop();

        // R4 current-address read
        bus_start(); wr_byte(8'b1010_101_1, 0, ack);
        rd_byte(0, d); check("R4 current address byte 8", d, model[8]);
        bus_stop();

        // R2 R3 R6 page write across wrap, with glitches
        bus_start(); wr_byte(8'b1010_101_0, 0, ack);
        wr_byte(8'hFE, 0, ack);
        wr_byte(8'hA1, 0, ack); check("R2 data ack 254", ack, 1); model[254] = 8'hA1;
        wr_byte(8'hB2, 1, ack); check("R6 glitchy byte ack", ack, 1); model[255] = 8'hB2;
        wr_byte(8'hC3, 0, ack); check("R3 data ack after wrap", ack, 1); model[0] = 8'hC3;
        bus_stop();

        // R5 busy window
        bus_start(); wr_byte(8'b1010_101_0, 0, ack);
        check("R5 busy nack", ack, 0);
        bus_stop();
        step(BUSY);
        bus_start(); wr_byte(8'b1010_101_1, 0, ack);
        check("R5 ack after window", ack, 1);
        rd_byte(0, d); check("R3 pointer wrapped to 1", d, model[1]);
        bus_stop();

        // R3 read across wrap
        bus_start(); wr_byte(8'b1010_101_0, 0, ack); wr_byte(8'hFF, 0, ack);
        bus_start(); wr_byte(8'b1010_101_1, 0, ack);
        rd_byte(1, d); check("R2 stored byte 255", d, model[255]);
        rd_byte(0, d); check("R3 read wraps to 0", d, model[0]);
        bus_stop();

        // R6 idle SDA glitch gives no START
        m_low = 1'b1; step(FILT-4); m_low = 1'b0; step(HP);
        bus_start(); wr_byte(8'b1010_101_1, 0, ack);
        rd_byte(0, d); check("R6 pointer unaffected by glitch", d, model[1]);
        bus_stop();

        check("R10 drive changes while SCL high", r10_viol, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule